// File: doc/BRIEF.md
# Inter-core mailbox send controller

This block is the transmit side of an inter-core mailbox. Software on the local core prepares a 64-bit message through a 32-bit register bus. It writes the lower and upper words and a target core number into staging registers, and then writes a go command. The go command copies the staged message into a small queue owned by that target. Each target core drains its own queue through a valid/fetch handshake. The word at the head of the queue is always presented on the target's message lane.

For every target, one status word reports three things: whether messages are still queued (busy), whether the remote side has fetched at least one message (delivered), and whether a go command was dropped because the queue was full (overflow). Software clears the delivered and overflow flags through a separate clear register. A single interrupt line follows a sticky pending flag. That flag is raised by delivery, overflow or queue-behind ("blocked") events, and each kind of event can be masked on its own.

Top module: `mbox_send_ctrl`

## Requirements
- R1: The staging registers are the destination number at offset 0x00 (bits [2:0]), the lower message word at 0x04 and the upper message word at 0x08. A read of each returns the last value written.
- R2: A write to offset 0x0C with bit 0 set enqueues {upper, lower} toward the staged destination. The target's `tgt_valid` bit rises after that clock edge, with the upper word in bits [63:32] of its 64-bit lane in `tgt_msg`. A write to 0x0C with bit 0 clear sends nothing.
- R3: Each target queue holds 4 messages and presents them in the order they were sent. A cycle with `tgt_fetch` and `tgt_valid` both high for a target removes its head entry. The head entry stays stable while it is not fetched.
- R4: In the status word at 0x14, bits [7:0] hold the busy flags. A target's bit is 1 exactly while its queue is not empty.
- R5: In the status word, bits [23:16] hold the delivery flags. A target's bit becomes 1 on every fetch that removes an entry. A fetch while that target's `tgt_valid` is low is ignored.
- R6: In the status word, bits [15:8] hold the overflow flags. A go command to a target whose queue is full at that clock edge drops the message and sets that target's overflow flag. The queue contents stay as they were.
- R7: Writing to the clear register at 0x10 clears every delivery and overflow flag whose status-word bit is 1 in the write data. Flags written 0 and all busy flags are unaffected. If a flag is set and cleared in the same cycle, it ends up set.
- R8: The mask register at 0x1C has bit 0 for blocked events, bit 1 for overflow events and bit 2 for delivery events. A 1 suppresses that source. The register resets to 3'b111 and reads back its value.
- R9: The pending flag, visible as bit 0 at 0x18 and on `irq`, goes high after the edge of any unmasked event. Writing 1 to 0x18 bit 0 clears it and writing 0 leaves it. If it is set and cleared in the same cycle, it ends up set.
- R10: A blocked event is a go command accepted into a target queue that already holds at least one message.
- R11: Reads of the go register (0x0C), the clear register (0x10) and any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tgt_valid | output | 8 | Per-target: head message available |
| tgt_fetch | input | 8 | Per-target: remote side takes the head message |
| tgt_msg | output | 512 | Per-target 64-bit head message, target t in bits [64t+63:64t] |
| irq | output | 1 | Interrupt, equal to the pending flag |

## Verification
The hardest condition to reach is the overflow drop. A full queue has to be built up with four back-to-back go commands before a fifth is refused. The bench then drains the same queue and confirms that only the first four messages come out, in order. The blocked event is also only reachable from a queue that is already occupied. The bench therefore sends twice to one target with only that interrupt source unmasked, and checks that the first send leaves `irq` low and the second raises it.

// File: rtl/mbox_pkg.sv
// Shared definitions for the mailbox send controller.
// Assumes a byte-offset register bus of ADDR_W bits and 32-bit words.
package mbox_pkg;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;
    localparam int MSG_W  = 2 * WORD_W;

    // Register offsets; software decodes these, so they are fixed.
    localparam logic [ADDR_W-1:0] OFS_DEST  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_WLO   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_WHI   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_GO    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h1C;

    // Status word field positions (one byte per flag kind).
    localparam int BUSY_LSB = 0;
    localparam int OVF_LSB  = 8;
    localparam int DLV_LSB  = 16;

    // Interrupt mask bit positions.
    localparam int MSK_BLK = 0;
    localparam int MSK_OVF = 1;
    localparam int MSK_DLV = 2;
    localparam int MSK_W   = 3;
endpackage

// File: rtl/mbox_tgt_fifo.sv
// Per-target message queue.
// A push while full and a pop while empty are ignored. Fullness and emptiness
// are those held before the clock edge. Storage carries no reset; only the
// pointers and the count do.
module mbox_tgt_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/mbox_flag_bank.sv
// Bank of sticky per-target flags.
// A flag set and cleared in the same cycle ends up set, so no event is lost.
module mbox_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    // Sticky update with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/mbox_irq_ctrl.sv
// Interrupt mask register and sticky pending flag.
// Events are single-cycle pulses, gated by the mask value held in the same
// cycle. A set and a clear in one cycle leave the pending flag set.
module mbox_irq_ctrl
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [MSK_W-1:0] mask_wdata,
    input  logic             pend_clr,
    input  logic             evt_blk,
    input  logic             evt_ovf,
    input  logic             evt_dlv,
    output logic [MSK_W-1:0] mask_q,
    output logic             pend_q
);
    logic pend_set;

    assign pend_set = (evt_blk && !mask_q[MSK_BLK]) ||
                      (evt_ovf && !mask_q[MSK_OVF]) ||
                      (evt_dlv && !mask_q[MSK_DLV]);

    // Mask register; every source is masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Pending flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (pend_set) pend_q <= 1'b1;
        else if (pend_clr) pend_q <= 1'b0;
    end
endmodule

// File: rtl/mbox_send_ctrl.sv
// Mailbox send controller top.
// Decodes register writes, holds the staged message and destination, queues
// messages per target, keeps the busy, overflow and delivery flags, and
// drives the interrupt. Reads are combinational from bus_addr.
// Assumes NUM_TGT <= 8 so that each flag kind fits one status byte.
module mbox_send_ctrl
    import mbox_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int Q_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    output logic [NUM_TGT-1:0]       tgt_valid,
    input  logic [NUM_TGT-1:0]       tgt_fetch,
    output logic [NUM_TGT*MSG_W-1:0] tgt_msg,
    output logic                     irq
);
    localparam int IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

    logic [IDX_W-1:0]   dest_q;
    logic [WORD_W-1:0]  wlo_q, whi_q;
    logic [NUM_TGT-1:0] push_vec, empty_vec, full_vec;
    logic [NUM_TGT-1:0] ovf_set, dlv_set, ovf_clr, dlv_clr, ovf_q, dlv_q;
    logic [MSK_W-1:0]   mask_q;
    logic               pend_q, go_hit, clr_hit, evt_blk;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[WORD_W-1:DLV_LSB+NUM_TGT];

    assign go_hit  = bus_wr && (bus_addr == OFS_GO) && bus_wdata[0];
    assign clr_hit = bus_wr && (bus_addr == OFS_CLR);

    // Staging registers for destination and both message words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= '0;
            wlo_q  <= '0;
            whi_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_DEST) dest_q <= bus_wdata[IDX_W-1:0];
            if (bus_addr == OFS_WLO)  wlo_q  <= bus_wdata;
            if (bus_addr == OFS_WHI)  whi_q  <= bus_wdata;
        end
    end

    // One queue per target, addressed by the staged destination.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        assign push_vec[t] = go_hit && (dest_q == IDX_W'(t));
        mbox_tgt_fifo #(.DEPTH(Q_DEPTH), .DW(MSG_W)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_vec[t]),
            .push_data ({whi_q, wlo_q}),
            .pop       (tgt_fetch[t]),
            .head      (tgt_msg[t*MSG_W +: MSG_W]),
            .empty     (empty_vec[t]),
            .full      (full_vec[t])
        );
        assign tgt_valid[t] = !empty_vec[t];
    end

    // Per-target event vectors and write-one-to-clear requests.
    assign ovf_set = push_vec & full_vec;
    assign dlv_set = tgt_fetch & ~empty_vec;
    assign evt_blk = |(push_vec & ~full_vec & ~empty_vec);
    assign ovf_clr = clr_hit ? bus_wdata[OVF_LSB +: NUM_TGT] : '0;
    assign dlv_clr = clr_hit ? bus_wdata[DLV_LSB +: NUM_TGT] : '0;

    mbox_flag_bank #(.N(NUM_TGT)) u_ovf (
        .clk(clk), .rst_n(rst_n), .set_vec(ovf_set), .clr_vec(ovf_clr), .flags(ovf_q)
    );
    mbox_flag_bank #(.N(NUM_TGT)) u_dlv (
        .clk(clk), .rst_n(rst_n), .set_vec(dlv_set), .clr_vec(dlv_clr), .flags(dlv_q)
    );

    mbox_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (bus_wr && (bus_addr == OFS_MASK)),
        .mask_wdata (bus_wdata[MSK_W-1:0]),
        .pend_clr   (bus_wr && (bus_addr == OFS_PEND) && bus_wdata[0]),
        .evt_blk    (evt_blk),
        .evt_ovf    (|ovf_set),
        .evt_dlv    (|dlv_set),
        .mask_q     (mask_q),
        .pend_q     (pend_q)
    );

    assign irq = pend_q;

    // Register read multiplexer; write-only and unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DEST: bus_rdata[IDX_W-1:0] = dest_q;
            OFS_WLO:  bus_rdata = wlo_q;
            OFS_WHI:  bus_rdata = whi_q;
            OFS_STAT: begin
                bus_rdata[BUSY_LSB +: NUM_TGT] = ~empty_vec;
                bus_rdata[OVF_LSB  +: NUM_TGT] = ovf_q;
                bus_rdata[DLV_LSB  +: NUM_TGT] = dlv_q;
            end
            OFS_PEND: bus_rdata[0] = pend_q;
            OFS_MASK: bus_rdata[MSK_W-1:0] = mask_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_send_ctrl_chk.sv
// Property checker for the mailbox send controller, attached by bind.
// Observes ports and the internal flag, event and fullness signals.
module mbox_send_ctrl_chk
    import mbox_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     go_bit,
    input logic [NUM_TGT-1:0]       tgt_valid,
    input logic [NUM_TGT-1:0]       tgt_fetch,
    input logic [NUM_TGT*MSG_W-1:0] tgt_msg,
    input logic                     irq,
    input logic [IDX_W-1:0]         dest_q,
    input logic [NUM_TGT-1:0]       full_vec,
    input logic [NUM_TGT-1:0]       ovf_q,
    input logic [NUM_TGT-1:0]       dlv_q,
    input logic [NUM_TGT-1:0]       ovf_clr,
    input logic [NUM_TGT-1:0]       ovf_set,
    input logic [NUM_TGT-1:0]       dlv_set,
    input logic                     evt_blk,
    input logic [MSK_W-1:0]         mask_q
);
    logic go_cmd, unmasked_evt;
    logic [NUM_TGT-1:0] took;

    assign go_cmd = bus_wr && (bus_addr == OFS_GO) && go_bit;
    assign took   = tgt_fetch & tgt_valid;
    assign unmasked_evt = (evt_blk && !mask_q[MSK_BLK]) ||
                          ((|ovf_set) && !mask_q[MSK_OVF]) ||
                          ((|dlv_set) && !mask_q[MSK_DLV]);

    AST_DELIV_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|took) |=> ((dlv_q & $past(took)) == $past(took))); // R5

    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cmd && full_vec[dest_q]) |=> ovf_q[$past(dest_q)]); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ovf_q) & ~$past(ovf_clr) & ~ovf_q) == '0)); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(unmasked_evt)); // R9

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_hold
        AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_valid[t] && !tgt_fetch[t]) |=>
            (tgt_valid[t] && $stable(tgt_msg[t*MSG_W +: MSG_W]))); // R3
    end
endmodule

bind mbox_send_ctrl mbox_send_ctrl_chk #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .go_bit    (bus_wdata[0]),
    .tgt_valid (tgt_valid),
    .tgt_fetch (tgt_fetch),
    .tgt_msg   (tgt_msg),
    .irq       (irq),
    .dest_q    (dest_q),
    .full_vec  (full_vec),
    .ovf_q     (ovf_q),
    .dlv_q     (dlv_q),
    .ovf_clr   (ovf_clr),
    .ovf_set   (ovf_set),
    .dlv_set   (dlv_set),
    .evt_blk   (evt_blk),
    .mask_q    (mask_q)
);

// File: tb/tb_mbox_send_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_mbox_send_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [7:0]   tgt_valid;
    logic [7:0]   tgt_fetch = '0;
    logic [511:0] tgt_msg;
    logic         irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    mbox_send_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_valid(tgt_valid),
        .tgt_fetch(tgt_fetch), .tgt_msg(tgt_msg), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic send(input int t, input logic [31:0] lo, input logic [31:0] hi);
        wr(8'h00, 32'(t));
        wr(8'h04, lo);
        wr(8'h08, hi);
        wr(8'h0C, 32'h1);
    endtask

    task automatic fetch(input int t);
        @(negedge clk);
        tgt_fetch[t] = 1'b1;
        @(negedge clk);
        tgt_fetch = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h14, d); check("R4 status after reset", 64'(d), 64'h0);
        rd(8'h1C, d); check("R8 mask reset value", 64'(d), 64'h7);
        rd(8'h18, d); check("R9 pending after reset", 64'(d), 64'h0);
        check("R9 irq after reset", 64'(irq), 64'h0);
        check("R2 no valid after reset", 64'(tgt_valid), 64'h0);
    endtask

    task automatic t_stage();
        logic [31:0] d;
        wr(8'h00, 32'h5);
        wr(8'h04, 32'hCAFE_0001);
        wr(8'h08, 32'hBEEF_0002);
        rd(8'h00, d); check("R1 dest readback", 64'(d), 64'h5);
        rd(8'h04, d); check("R1 low readback", 64'(d), 64'hCAFE_0001);
        rd(8'h08, d); check("R1 high readback", 64'(d), 64'hBEEF_0002);
        wr(8'h0C, 32'h0);
        check("R2 go with bit0 clear sends nothing", 64'(tgt_valid), 64'h0);
        rd(8'h0C, d); check("R11 go reads zero", 64'(d), 64'h0);
        rd(8'h10, d); check("R11 clear reads zero", 64'(d), 64'h0);
        rd(8'h24, d); check("R11 unmapped reads zero", 64'(d), 64'h0);
    endtask

    task automatic t_send_fetch();
        logic [31:0] d;
        send(3, 32'h1111_2222, 32'h3333_4444);
        check("R2 valid for target 3", 64'(tgt_valid), 64'h08);
        check("R2 message lane 3", tgt_msg[3*64 +: 64], 64'h3333_4444_1111_2222);
        rd(8'h14, d); check("R4 busy bit 3", 64'(d), 64'h0000_0008);
        check("R8 masked delivery source keeps irq low", 64'(irq), 64'h0);
        fetch(3);
        check("R3 queue empty after fetch", 64'(tgt_valid), 64'h0);
        rd(8'h14, d); check("R5 delivery bit 19 set", 64'(d), 64'h0008_0000);
        fetch(0);
        rd(8'h14, d); check("R5 fetch without valid ignored", 64'(d), 64'h0008_0000);
        wr(8'h10, 32'h0008_0000);
        rd(8'h14, d); check("R7 delivery flag cleared", 64'(d), 64'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) send(6, 32'(i), 32'hA000_0000 + 32'(i));
        rd(8'h14, d); check("R6 four sends fit", 64'(d), 64'h0000_0040);
        send(6, 32'h99, 32'h99);
        rd(8'h14, d); check("R6 fifth send overflows", 64'(d), 64'h0000_4040);
        for (int i = 0; i < 4; i++) begin
            check("R3 in-order head", tgt_msg[6*64 +: 64], {32'hA000_0000 + 32'(i), 32'(i)});
            fetch(6);
        end
        check("R6 dropped message absent", 64'(tgt_valid[6]), 64'h0);
        rd(8'h14, d); check("R5 delivery and overflow after drain", 64'(d), 64'h0040_4000);
        send(6, 32'h5, 32'h6);
        wr(8'h10, 32'h0040_0040);
        rd(8'h14, d); check("R7 clear spares busy and unwritten overflow", 64'(d), 64'h0000_4040);
        fetch(6);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R7 clear all flags", 64'(d), 64'h0);
    endtask

    task automatic t_irq_dlv();
        logic [31:0] d;
        wr(8'h1C, 32'h3);
        rd(8'h1C, d); check("R8 mask readback", 64'(d), 64'h3);
        send(1, 32'h1, 32'h2);
        check("R8 send alone raises nothing", 64'(irq), 64'h0);
        fetch(1);
        check("R9 delivery raises irq", 64'(irq), 64'h1);
        rd(8'h18, d); check("R9 pending readback", 64'(d), 64'h1);
        wr(8'h18, 32'h0);
        check("R9 writing 0 keeps pending", 64'(irq), 64'h1);
        wr(8'h18, 32'h1);
        check("R9 writing 1 clears pending", 64'(irq), 64'h0);
        wr(8'h10, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq_ovf();
        for (int i = 0; i < 4; i++) send(2, 32'(i), 32'h0);
        check("R8 blocked masked, no irq", 64'(irq), 64'h0);
        send(2, 32'h7, 32'h7);
        check("R6 overflow raises irq", 64'(irq), 64'h1);
        wr(8'h18, 32'h1);
        for (int i = 0; i < 4; i++) fetch(2);
        check("R8 delivery masked, no irq", 64'(irq), 64'h0);
        wr(8'h10, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq_blk();
        wr(8'h1C, 32'h6);
        send(4, 32'h1, 32'h1);
        check("R10 first send is not blocked", 64'(irq), 64'h0);
        send(4, 32'h2, 32'h2);
        check("R10 send behind queued message raises irq", 64'(irq), 64'h1);
        wr(8'h18, 32'h1);
        fetch(4);
        fetch(4);
        check("R10 drain does not raise irq", 64'(irq), 64'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage();
        t_send_fetch();
        t_overflow();
        wr(8'h1C, 32'h5);
        t_irq_ovf();
        wr(8'h1C, 32'h3);
        t_irq_dlv();
        t_irq_blk();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule